// File: doc/BRIEF.md
# Vertical Cursor Row Counter

This block holds the row of the text cursor on a character display of 24 rows. The row is stored as a count from 0 (top line) to 23 (bottom line). On each clock where a command is presented, the row either steps up or down by one or takes a new value from a small source selector. The selector decides between an explicit row address, the current last-line value kept by a scroll tracker, and zero.

Stepping past either end of the range wraps round: going down from row 23 gives row 0, and going up from row 0 gives row 23. A home request behaves differently in the two display modes. In scroll mode the row jumps to the line that is currently the last one. In page mode the row jumps to row 0. Explicit row addressing is accepted only in page mode. The block also drives two flags that mark the top row and the bottom row, for use by the command logic.

Top module: `vcursor_row`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it rises, row_o is 0, at_min_o is 1 and at_max_o is 0.
- R2: A cycle with cnt_en_i=1, ld_en_i=0, dir_dn_i=0 and row_o below 23 makes row_o one larger at the next cycle.
- R3: A cycle with cnt_en_i=1, ld_en_i=0, dir_dn_i=1 and row_o above 0 makes row_o one smaller at the next cycle.
- R4: Counting with dir_dn_i=0 while row_o is 23 makes row_o 0 at the next cycle.
- R5: Counting with dir_dn_i=1 while row_o is 0 makes row_o 23 at the next cycle.
- R6: A load (ld_en_i=1) with page_i=1, home_i=0 and pos_i=1 sets row_o to row_val_i. A value above 23 is clamped to 23.
- R7: A load with page_i=0, home_i=0 and pos_i=1 is blocked, and row_o keeps its value.
- R8: A load with page_i=0 and home_i=1 sets row_o to last_line_i. A value above 23 is clamped to 23.
- R9: A load with page_i=1 and home_i=1 sets row_o to 0, whatever the value of pos_i.
- R10: A load with home_i=0 and pos_i=0 leaves row_o unchanged. A cycle with both cnt_en_i and ld_en_i low also leaves row_o unchanged.
- R11: at_min_o is 1 exactly when row_o is 0, and at_max_o is 1 exactly when row_o is 23.
- R12: row_o never exceeds 23.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_en_i | input | 1 | Step the row up or down this cycle |
| ld_en_i | input | 1 | Load the row from the source selector this cycle |
| dir_dn_i | input | 1 | Step direction: 0 counts up, 1 counts down |
| page_i | input | 1 | Display mode: 1 is page mode, 0 is scroll mode |
| home_i | input | 1 | Home request for a load |
| pos_i | input | 1 | Explicit row address request for a load |
| row_val_i | input | 5 | Explicit row value |
| last_line_i | input | 5 | Current last-line value from the scroll tracker |
| row_o | output | 5 | Current cursor row, 0 to 23 |
| at_min_o | output | 1 | Row is 0 |
| at_max_o | output | 1 | Row is 23 |

## Verification
The checker assumes that count-enable and load-enable are never high in the same cycle. Every stepping and loading property is written with the other enable low, so no property says anything about that combination. The bench keeps to this rule. Its directed phase raises only one enable per cycle, and its random phase picks one of three exclusive actions (idle, count, load) per cycle. The mode bit, the request bits and both row values are drawn freely, including values above 23, so that the blocked-address case and the clamping are both reached.

// File: rtl/vrow_pkg.sv
package vrow_pkg;
  typedef enum logic [1:0] {
    SRC_HOLD = 2'd0,
    SRC_ZERO = 2'd1,
    SRC_LAST = 2'd2,
    SRC_ADDR = 2'd3
  } vrow_src_e;
endpackage

// File: rtl/vrow_clamp.sv
module vrow_clamp #(
  parameter int NUM_ROWS = 24,
  parameter int ROW_W    = $clog2(NUM_ROWS)
) (
  input  logic [ROW_W-1:0] val_i,
  output logic [ROW_W-1:0] val_o
);
  localparam logic [ROW_W-1:0] ROW_MAX = ROW_W'(NUM_ROWS - 1);

  always_comb val_o = (val_i > ROW_MAX) ? ROW_MAX : val_i;
endmodule

// File: rtl/vrow_step.sv
module vrow_step #(
  parameter int NUM_ROWS = 24,
  parameter int ROW_W    = $clog2(NUM_ROWS)
) (
  input  logic [ROW_W-1:0] row_i,
  input  logic             dir_dn_i,
  output logic [ROW_W-1:0] nxt_o
);
  localparam logic [ROW_W-1:0] ROW_MAX = ROW_W'(NUM_ROWS - 1);
  localparam logic [ROW_W-1:0] ROW_MIN = '0;
  localparam logic [ROW_W-1:0] ONE     = ROW_W'(1);

  logic at_end;

  // end-of-range carry steers the wrap value instead of the adder
  always_comb begin
    at_end = dir_dn_i ? (row_i == ROW_MIN) : (row_i == ROW_MAX);
    if (at_end)        nxt_o = dir_dn_i ? ROW_MAX : ROW_MIN;
    else if (dir_dn_i) nxt_o = row_i - ONE;
    else               nxt_o = row_i + ONE;
  end
endmodule

// File: rtl/vrow_src_mux.sv
module vrow_src_mux
  import vrow_pkg::*;
#(
  parameter int NUM_ROWS = 24,
  parameter int ROW_W    = $clog2(NUM_ROWS)
) (
  input  logic             page_i,
  input  logic             home_i,
  input  logic             pos_i,
  input  logic [ROW_W-1:0] row_val_i,
  input  logic [ROW_W-1:0] last_line_i,
  input  logic [ROW_W-1:0] cur_i,
  output vrow_src_e        src_o,
  output logic [ROW_W-1:0] ld_val_o
);
  localparam int NSRC = 2;

  logic [ROW_W-1:0] raw [NSRC];
  logic [ROW_W-1:0] lim [NSRC];

  assign raw[0] = row_val_i;
  assign raw[1] = last_line_i;

  for (genvar g = 0; g < NSRC; g++) begin : g_clamp
    vrow_clamp #(.NUM_ROWS(NUM_ROWS), .ROW_W(ROW_W)) u_clamp (
      .val_i(raw[g]),
      .val_o(lim[g])
    );
  end

  // home outranks addressing; addressing is page-mode only
  always_comb begin
    if (home_i)               src_o = page_i ? SRC_ZERO : SRC_LAST;
    else if (pos_i && page_i) src_o = SRC_ADDR;
    else                      src_o = SRC_HOLD;
  end

  always_comb begin
    unique case (src_o)
      SRC_ZERO: ld_val_o = '0;
      SRC_LAST: ld_val_o = lim[1];
      SRC_ADDR: ld_val_o = lim[0];
      default:  ld_val_o = cur_i;
    endcase
  end
endmodule

// File: rtl/vcursor_row.sv
module vcursor_row
  import vrow_pkg::*;
#(
  parameter int NUM_ROWS = 24,
  parameter int ROW_W    = $clog2(NUM_ROWS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_en_i,
  input  logic             ld_en_i,
  input  logic             dir_dn_i,
  input  logic             page_i,
  input  logic             home_i,
  input  logic             pos_i,
  input  logic [ROW_W-1:0] row_val_i,
  input  logic [ROW_W-1:0] last_line_i,
  output logic [ROW_W-1:0] row_o,
  output logic             at_min_o,
  output logic             at_max_o
);
  localparam logic [ROW_W-1:0] ROW_MAX = ROW_W'(NUM_ROWS - 1);

  logic [ROW_W-1:0] row_q, row_d, step_val, ld_val;
  vrow_src_e        src;

  vrow_step #(.NUM_ROWS(NUM_ROWS), .ROW_W(ROW_W)) u_step (
    .row_i   (row_q),
    .dir_dn_i(dir_dn_i),
    .nxt_o   (step_val)
  );

  vrow_src_mux #(.NUM_ROWS(NUM_ROWS), .ROW_W(ROW_W)) u_mux (
    .page_i     (page_i),
    .home_i     (home_i),
    .pos_i      (pos_i),
    .row_val_i  (row_val_i),
    .last_line_i(last_line_i),
    .cur_i      (row_q),
    .src_o      (src),
    .ld_val_o   (ld_val)
  );

  always_comb begin
    if (ld_en_i)       row_d = ld_val;
    else if (cnt_en_i) row_d = step_val;
    else               row_d = row_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) row_q <= '0;
    else         row_q <= row_d;
  end

  assign row_o    = row_q;
  assign at_min_o = (row_q == '0);
  assign at_max_o = (row_q == ROW_MAX);
endmodule

// File: rtl/vcursor_row_chk.sv
module vcursor_row_chk #(
  parameter int NUM_ROWS = 24,
  parameter int ROW_W    = $clog2(NUM_ROWS)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cnt_en_i,
  input logic             ld_en_i,
  input logic             dir_dn_i,
  input logic             page_i,
  input logic             home_i,
  input logic             pos_i,
  input logic [ROW_W-1:0] row_o,
  input logic             at_min_o,
  input logic             at_max_o
);
  localparam logic [ROW_W-1:0] ROW_MAX = ROW_W'(NUM_ROWS - 1);
  localparam logic [ROW_W-1:0] ONE     = ROW_W'(1);

  assert_inc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_en_i && !ld_en_i && !dir_dn_i && row_o != ROW_MAX |=> row_o == $past(row_o) + ONE);

  assert_dec_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_en_i && !ld_en_i && dir_dn_i && row_o != '0 |=> row_o == $past(row_o) - ONE);

  assert_wrap_up_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_en_i && !ld_en_i && !dir_dn_i && row_o == ROW_MAX |=> row_o == '0);

  assert_wrap_dn_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_en_i && !ld_en_i && dir_dn_i && row_o == '0 |=> row_o == ROW_MAX);

  assert_addr_blocked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_en_i && !cnt_en_i && !page_i && !home_i && pos_i |=> $stable(row_o));

  assert_home_page_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_en_i && !cnt_en_i && page_i && home_i |=> row_o == '0);

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_en_i && !ld_en_i) || (ld_en_i && !cnt_en_i && !home_i && !pos_i) |=> $stable(row_o));

  assert_flags_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (at_min_o == (row_o == '0)) && (at_max_o == (row_o == ROW_MAX)));

  assert_range_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_o <= ROW_MAX);
endmodule

bind vcursor_row vcursor_row_chk #(.NUM_ROWS(NUM_ROWS), .ROW_W(ROW_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cnt_en_i(cnt_en_i),
  .ld_en_i (ld_en_i),
  .dir_dn_i(dir_dn_i),
  .page_i  (page_i),
  .home_i  (home_i),
  .pos_i   (pos_i),
  .row_o   (row_o),
  .at_min_o(at_min_o),
  .at_max_o(at_max_o)
);

// File: tb/sim_vcursor_row.sv
`timescale 1ns/1ps
module sim_vcursor_row;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cnt_en = 0, ld_en = 0, dir_dn = 0, page = 0, home = 0, pos = 0;
  logic [4:0] row_val = '0, last_line = '0;
  logic [4:0] row;
  logic at_min, at_max;
  int total = 0, bad = 0;
  int mrow = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vcursor_row u0 (
    .clk_i(clk), .rst_ni(rst_n), .cnt_en_i(cnt_en), .ld_en_i(ld_en),
    .dir_dn_i(dir_dn), .page_i(page), .home_i(home), .pos_i(pos),
    .row_val_i(row_val), .last_line_i(last_line),
    .row_o(row), .at_min_o(at_min), .at_max_o(at_max)
  );

  function automatic int lim23(int v);
    return (v > 23) ? 23 : v;
  endfunction

  task automatic check(string tag);
    total++;
    if (int'(row) != mrow) begin
      bad++; $display("FAIL %s row act=%0d exp=%0d", tag, row, mrow);
    end
    total++;
    if (at_min !== (mrow == 0) || at_max !== (mrow == 23)) begin
      bad++; $display("FAIL %s/R11 flags act=%b%b exp=%b%b", tag, at_min, at_max,
                      mrow == 0, mrow == 23);
    end
  endtask

  // inputs set at negedge, model advanced at posedge, outputs checked at next negedge
  task automatic cyc(bit c, bit l, bit d, bit pg, bit h, bit p, int rv, int ll, string tag);
    cnt_en = c; ld_en = l; dir_dn = d; page = pg; home = h; pos = p;
    row_val = 5'(rv); last_line = 5'(ll);
    @(posedge clk);
    if (l) begin
      if (h) mrow = pg ? 0 : lim23(ll);
      else if (p && pg) mrow = lim23(rv);
    end else if (c) begin
      if (d) mrow = (mrow == 0) ? 23 : mrow - 1;
      else   mrow = (mrow == 23) ? 0 : mrow + 1;
    end
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1");
    for (int i = 0; i < 23; i++) cyc(1, 0, 0, 0, 0, 0, 0, 0, "R2");
    cyc(1, 0, 0, 0, 0, 0, 0, 0, "R4");
    cyc(1, 0, 1, 0, 0, 0, 0, 0, "R5");
    for (int i = 0; i < 5; i++) cyc(1, 0, 1, 1, 0, 0, 0, 0, "R3");
    cyc(0, 1, 0, 1, 0, 1, 7, 0, "R6");
    cyc(0, 1, 0, 1, 0, 1, 30, 0, "R6");
    cyc(0, 1, 0, 1, 0, 1, 0, 0, "R6");
    cyc(0, 1, 0, 1, 0, 1, 23, 0, "R6");
    cyc(0, 1, 0, 0, 0, 1, 4, 0, "R7");
    cyc(0, 1, 0, 0, 1, 0, 0, 17, "R8");
    cyc(0, 1, 0, 0, 0, 1, 31, 2, "R7");
    cyc(0, 1, 0, 0, 1, 1, 3, 31, "R8");
    cyc(0, 1, 0, 1, 1, 0, 0, 12, "R9");
    cyc(0, 1, 0, 1, 0, 1, 9, 0, "R6");
    cyc(0, 1, 0, 1, 1, 1, 15, 5, "R9");
    cyc(0, 1, 0, 1, 0, 1, 11, 0, "R6");
    cyc(0, 1, 0, 1, 0, 0, 20, 20, "R10");
    cyc(0, 0, 1, 1, 1, 1, 2, 2, "R10");
    for (int i = 0; i < 2000; i++) begin
      int act = $urandom_range(0, 2);
      cyc(act == 1, act == 2, 1'($urandom), 1'($urandom), 1'($urandom),
          1'($urandom), $urandom_range(0, 31), $urandom_range(0, 31), "R12");
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule